// File: doc/BRIEF.md
# Complement-Checked Laser Drive Register Bank

This block keeps the settings that control a pulsed laser driver and refuses to pass them on unless they are self-consistent. Software writes four byte-wide registers over a plain parallel bus: a control byte, its complement, a drive-current code, and the complement of that code. Every safety-relevant bit is therefore stored twice, once true and once inverted. A combinational checker compares each pair. Only a fully consistent set reaches the drive stage: the current range, the bin-match bit, the calibration flag and the current code. An inconsistent set forces the drive off and raises a mismatch flag.

The block also produces the laser drive-enable signal. A small state machine has four states: `ST_OFF` (settings inconsistent, drive dark), `ST_IDLE` (normal mode, waiting for a frame tick), `ST_PULSE` (drive on for a fixed number of cycles) and `ST_CONT` (calibration mode, drive on at full duty).

Any state moves to `ST_OFF` when the check fails. `ST_OFF` goes to `ST_CONT` if the consistent set selects calibration, and to `ST_IDLE` otherwise. `ST_IDLE` goes to `ST_CONT` on calibration, and to `ST_PULSE` on a frame tick. `ST_PULSE` goes to `ST_CONT` on calibration. It returns to `ST_IDLE` when its count runs out. `ST_CONT` returns to `ST_IDLE` when calibration is cleared.

After reset the register contents fail the check on purpose, so the laser stays dark until a valid set has been written.

Top module: `lsr_safe_regs`

## Requirements
- R1: A write (bus_we high at a clock edge) to address 0x1A (control), 0x1F (control complement), 0x1C (current) or 0x1D (current complement) stores the data byte. Reading bus_rdata with that address returns the stored byte in the same cycle. Any other address reads 0x00.
- R2: After reset all four registers read 0x00, mismatch is 1, drv_en is 0 and cur_code is 0x00.
- R3: The set is consistent when control XOR control-complement has bits 7, 5, 3, 2 and 1 all set, and current XOR current-complement is 0xFF. Control bits 6, 4 and 0 take no part in the comparison.
- R4: While the set is consistent, the outputs follow the stored values: range_hi is control bit 7 (1 selects the higher current range), match_sel is control bit 5, calib_mode is 1 exactly when control bits [3:1] are 3'b111, and cur_code is the current register. While the set is inconsistent, all four outputs are 0.
- R5: mismatch is the inverse of consistency and changes in the cycle the registers change. While mismatch is 1, drv_en is 0.
- R6: In normal mode, a frame_tick sampled high in `ST_IDLE` raises drv_en from the next cycle for exactly PULSE_CYC cycles (default 4). Ticks seen during a pulse are ignored.
- R7: When a consistent set selecting calibration is completed, drv_en is high from the second cycle after the completing write and stays high while that set holds.
- R8: Writes to any address other than the four listed change no register.
- R9: Clearing calibration with a consistent normal-mode set leaves drv_en low until the next frame tick.
- R10: The minimum-current pair, code 0x00 with complement 0xFF, is consistent and forwards cur_code 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| frame_tick | input | 1 | One pulse per frame period |
| drv_en | output | 1 | Laser drive enable |
| cur_code | output | 8 | Drive current code |
| range_hi | output | 1 | Higher current range selected |
| match_sel | output | 1 | Laser bin match bit |
| calib_mode | output | 1 | Continuous-drive calibration active |
| mismatch | output | 1 | Complement check failed |

## Verification
A wrong comparison mask or a corrupted register shows up at once on mismatch and on the gated setting outputs, in the cycle after the offending write. A state machine stuck in the wrong state shows up on drv_en. It either fails to rise one cycle after a tick, pulses for a length other than PULSE_CYC, or keeps driving after calibration is cleared. It can also fail to reach full duty two cycles after a calibration set is completed. Because drv_en is gated by the checker directly, a mismatch that still lets drive through is visible in the same cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int NREG   = 4;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_CTRL_N = 1;
    localparam int IDX_CUR    = 2;
    localparam int IDX_CUR_N  = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h1A;
    localparam logic [ADDR_W-1:0] ADDR_CTRL_N = 8'h1F;
    localparam logic [ADDR_W-1:0] ADDR_CUR    = 8'h1C;
    localparam logic [ADDR_W-1:0] ADDR_CUR_N  = 8'h1D;

    // bits 7 (range), 5 (match), 3:1 (calibration) are compared
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'hAE;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_PULSE,
        ST_CONT
    } drv_state_t;

    function automatic logic [ADDR_W-1:0] reg_addr(input int idx);
        case (idx)
            IDX_CTRL:   reg_addr = ADDR_CTRL;
            IDX_CTRL_N: reg_addr = ADDR_CTRL_N;
            IDX_CUR:    reg_addr = ADDR_CUR;
            default:    reg_addr = ADDR_CUR_N;
        endcase
    endfunction
endpackage

// File: rtl/lsr_regfile.sv
module lsr_regfile
    import lsr_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NREG-1:0][DATA_W-1:0]  regs
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign hit[g] = (addr == reg_addr(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && hit[g])
                regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rdata = regs[i];
    end

    AST_IGNORE_UNLISTED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit == '0) |=> $stable(regs)); // R8
endmodule

// File: rtl/lsr_pair_check.sv
module lsr_pair_check
    import lsr_pkg::*;
(
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] ctrl_n,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] cur_n,
    output logic              ok
);
    logic ctrl_ok;
    logic cur_ok;

    always_comb begin
        ctrl_ok = (((ctrl ^ ctrl_n) & CTRL_MASK) == CTRL_MASK);
        cur_ok  = ((cur ^ cur_n) == {DATA_W{1'b1}});
        ok      = ctrl_ok && cur_ok;
    end
endmodule

// File: rtl/lsr_drive_fsm.sv
module lsr_drive_fsm
    import lsr_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    input  logic calib,
    input  logic tick,
    output logic drv_on
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    drv_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!ok) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:   st_d = calib ? ST_CONT : ST_IDLE;
                ST_IDLE: begin
                    if (calib) st_d = ST_CONT;
                    else if (tick) begin
                        st_d  = ST_PULSE;
                        cnt_d = CNT_LOAD;
                    end
                end
                ST_PULSE: begin
                    if (calib) st_d = ST_CONT;
                    else if (cnt_q == '0) st_d = ST_IDLE;
                    else cnt_d = cnt_q - 1'b1;
                end
                ST_CONT:  if (!calib) st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb drv_on = ok && (st_q == ST_PULSE || st_q == ST_CONT);

    // independent run-length counter for the pulse window
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (st_q == ST_PULSE) run_q <= run_q + 1'b1;
        else                       run_q <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PULSE) |-> (run_q < (CNT_W+1)'(PULSE_CYC))); // R6
    AST_OFF_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> (st_q == ST_OFF)); // R5
endmodule

// File: rtl/lsr_safe_regs.sv
module lsr_safe_regs
    import lsr_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_tick,
    output logic              drv_en,
    output logic [DATA_W-1:0] cur_code,
    output logic              range_hi,
    output logic              match_sel,
    output logic              calib_mode,
    output logic              mismatch
);
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic ok;
    logic calib_raw;

    lsr_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .regs  (regs)
    );

    lsr_pair_check u_chk (
        .ctrl   (regs[IDX_CTRL]),
        .ctrl_n (regs[IDX_CTRL_N]),
        .cur    (regs[IDX_CUR]),
        .cur_n  (regs[IDX_CUR_N]),
        .ok     (ok)
    );

    assign calib_raw = (regs[IDX_CTRL][3:1] == 3'b111);

    lsr_drive_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ok     (ok),
        .calib  (calib_raw),
        .tick   (frame_tick),
        .drv_on (drv_en)
    );

    always_comb begin
        mismatch   = !ok;
        range_hi   = ok && regs[IDX_CTRL][7];
        match_sel  = ok && regs[IDX_CTRL][5];
        calib_mode = ok && calib_raw;
        cur_code   = ok ? regs[IDX_CUR] : '0;
    end

    AST_DARK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> !drv_en); // R5
    AST_GATED_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> (cur_code == '0 && !range_hi && !match_sel && !calib_mode)); // R4
    AST_CALIB_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (calib_mode && $past(calib_mode)) |-> drv_en); // R7
endmodule

// File: tb/sim_lsr_safe_regs.sv
module sim_lsr_safe_regs;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       frame_tick = 1'b0;
    logic       drv_en;
    logic [7:0] cur_code;
    logic       range_hi, match_sel, calib_mode, mismatch;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lsr_safe_regs #(.PULSE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
        .drv_en(drv_en), .cur_code(cur_code), .range_hi(range_hi),
        .match_sel(match_sel), .calib_mode(calib_mode), .mismatch(mismatch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd("R2 ctrl", 8'h1A, 8'h00);
        rd("R2 ctrl_n", 8'h1F, 8'h00);
        rd("R2 cur", 8'h1C, 8'h00);
        rd("R2 cur_n", 8'h1D, 8'h00);
        check("R2 mismatch", mismatch, 1);
        check("R2 drv_en", drv_en, 0);
        check("R2 cur_code", cur_code, 0);
    endtask

    task automatic t_readback;
        wr(8'h1A, 8'h5A); wr(8'h1F, 8'h3C); wr(8'h1C, 8'h81); wr(8'h1D, 8'h7E);
        rd("R1 ctrl", 8'h1A, 8'h5A);
        rd("R1 ctrl_n", 8'h1F, 8'h3C);
        rd("R1 cur", 8'h1C, 8'h81);
        rd("R1 cur_n", 8'h1D, 8'h7E);
        rd("R1 unlisted", 8'h1B, 8'h00);
    endtask

    task automatic t_ignore;
        wr(8'h1E, 8'hFF); wr(8'h00, 8'hFF);
        rd("R8 ctrl kept", 8'h1A, 8'h5A);
        rd("R8 cur_n kept", 8'h1D, 8'h7E);
        rd("R8 ctrl_n kept", 8'h1F, 8'h3C);
    endtask

    task automatic t_valid_normal;
        wr(8'h1A, 8'hA0); wr(8'h1F, 8'h5F); wr(8'h1C, 8'h40); wr(8'h1D, 8'hBF);
        check("R3 consistent", mismatch, 0);
        check("R4 range_hi", range_hi, 1);
        check("R4 match_sel", match_sel, 1);
        check("R4 calib_mode", calib_mode, 0);
        check("R4 cur_code", cur_code, 8'h40);
        repeat (3) @(negedge clk);
        check("R6 idle dark", drv_en, 0);
    endtask

    task automatic t_pulse;
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        for (int i = 0; i < P + 3; i++) begin
            check($sformatf("R6 pulse cycle %0d", i), drv_en, (i < P) ? 1 : 0);
            @(negedge clk);
            frame_tick = (i == 0);
        end
        frame_tick = 1'b0;
    endtask

    task automatic t_dontcare_bits;
        wr(8'h1A, 8'hF1); wr(8'h1F, 8'h5F);
        check("R3 bits 6,4,0 ignored", mismatch, 0);
        wr(8'h1D, 8'hBE);
        check("R3 cur bit mismatch", mismatch, 1);
        check("R4 gated cur_code", cur_code, 0);
        check("R4 gated range", range_hi, 0);
        check("R5 dark", drv_en, 0);
        wr(8'h1A, 8'h20); wr(8'h1F, 8'h5F);
        wr(8'h1D, 8'hBF);
        check("R3 ctrl bit7 equal", mismatch, 1);
    endtask

    task automatic t_calib;
        wr(8'h1A, 8'h0E); wr(8'h1F, 8'hF1);
        check("R4 calib_mode", calib_mode, 1);
        check("R4 range low", range_hi, 0);
        check("R7 first cycle", drv_en, 0);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check("R7 full duty", drv_en, 1);
            @(negedge clk);
        end
        wr(8'h1A, 8'h00);
        check("R5 partial update dark", drv_en, 0);
        check("R5 partial mismatch", mismatch, 1);
        wr(8'h1F, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            check("R9 dark after calib", drv_en, 0);
            @(negedge clk);
        end
        check("R9 consistent", mismatch, 0);
    endtask

    task automatic t_min_current;
        wr(8'h1C, 8'h00); wr(8'h1D, 8'hFF);
        check("R10 consistent", mismatch, 0);
        check("R10 cur_code", cur_code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_readback;
        t_ignore;
        t_valid_normal;
        t_pulse;
        t_dontcare_bits;
        t_calib;
        t_min_current;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule